// File: doc/BRIEF.md
# CPU Address Decode Window Unit

This unit maps a CPU physical address onto an interconnect target. Eight decode windows are programmed through a small word-wide register port. Each window has a control word and a base word. The control word carries the size, an attribute byte, an enable bit and a target ID. Only the two lowest windows also carry a remap base, split into a low word and a high word. These two windows can move the address into another region, and they supply an upper address word.

On every clock the lookup port compares the presented address against all windows in parallel. The lowest-numbered enabled window that matches is selected. One cycle later the unit reports:

- a hit flag,
- the target ID,
- the attribute,
- the translated address and its upper word.

When no window matches, the unit reports a miss. On a miss the target, attribute and upper word are all zero, and the address passes through unchanged.

Top module: `addr_window_decoder`

## Requirements
- R1: After reset every register reads zero, every window is disabled, and every lookup misses.
- R2: Each window's registers sit at byte offset window*16: control at +0, base at +4, remap-low at +8 and remap-high at +12.
- R2 (control word fields): size-minus-one in 64 KB units in bits 31:16, attribute in bits 15:8, enable in bit 5 and target ID in bits 3:0. The control word reads back only those bits; other bits read as zero.
- R3: The base register and the remap-low register keep only bits 31:16; bits 15:0 read back as zero.
- R4: The remap-low and remap-high offsets exist only for windows 0 and 1. For windows 2 to 7, writes to those offsets are ignored and reads return zero. Remap-high keeps all 32 bits.
- R5: A window matches when its enable bit is set and address bits 31:16 equal base bits 31:16 in every position where the size field holds a zero.
- R6: A window whose enable bit is clear never produces a hit, whatever its base and size.
- R7: When several enabled windows match, the lowest-numbered one supplies the target, attribute and translated address.
- R8: For a hit in window 0 or 1, the translated address is formed from two parts. Bits 31:16 take the remap-low bits where the size field is zero and the address bits where it is one. Bits 15:0 are the address bits. The upper word equals that window's remap-high register.
- R9: For a hit in windows 2 to 7, the translated address equals the lookup address and the upper word is zero.
- R10: On a miss, the hit flag, target, attribute and upper word are zero, and the translated address equals the lookup address.
- R11: Lookup results appear on the clock after the address is presented. A register write is visible to a lookup presented on the clock after the write.
- R12: Read data appears on the clock after a read strobe and is zero on any clock that follows no read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_re | input | 1 | Register read strobe |
| cfg_addr | input | 7 | Register byte offset |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, one cycle after cfg_re |
| lk_addr | input | 32 | Address to decode |
| lk_hit | output | 1 | A window matched |
| lk_target | output | 4 | Target ID of the selected window |
| lk_attr | output | 8 | Attribute of the selected window |
| lk_xaddr | output | 32 | Translated address |
| lk_xaddr_hi | output | 32 | Upper word of the translated address |

## Verification
The hardest case to reach from the ports has three conditions at once: one address falls inside two enabled windows of different sizes, the lower-numbered of the two remaps, and the address then steps just outside the smaller window. The stimulus builds this layout step by step. It programs a large non-remapping window and then a one-granule remapping window at the same base. It probes the address inside the small window, where the remapped result is expected. It then probes the next 64 KB granule, which must fall back to the larger window with a pass-through address. It also enables windows with writes placed directly before lookups, to expose any extra cycle of delay.

// File: rtl/addr_window_decoder.sv
module addr_window_decoder #(
  parameter int NUM_WIN   = 8,
  parameter int REMAP_WIN = 2,
  localparam int WIN_W    = $clog2(NUM_WIN),
  localparam int CFG_AW   = WIN_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_re,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic [31:0]       lk_addr,
  output logic              lk_hit,
  output logic [3:0]        lk_target,
  output logic [7:0]        lk_attr,
  output logic [31:0]       lk_xaddr,
  output logic [31:0]       lk_xaddr_hi
);

  logic [15:0] size_q [NUM_WIN];
  logic [7:0]  attr_q [NUM_WIN];
  logic        en_q   [NUM_WIN];
  logic [3:0]  tgt_q  [NUM_WIN];
  logic [15:0] base_q [NUM_WIN];
  logic [15:0] rlo_q  [REMAP_WIN];
  logic [31:0] rhi_q  [REMAP_WIN];

  wire [WIN_W-1:0] cfg_win = cfg_addr[CFG_AW-1:4];
  wire [1:0]       cfg_reg = cfg_addr[3:2];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_WIN; i++) begin
      if (!rst_n) begin
        size_q[i] <= '0;
        attr_q[i] <= '0;
        en_q[i]   <= 1'b0;
        tgt_q[i]  <= '0;
        base_q[i] <= '0;
      end else if (cfg_we && cfg_win == WIN_W'(i)) begin
        if (cfg_reg == 2'd0) begin
          size_q[i] <= cfg_wdata[31:16];
          attr_q[i] <= cfg_wdata[15:8];
          en_q[i]   <= cfg_wdata[5];
          tgt_q[i]  <= cfg_wdata[3:0];
        end
        if (cfg_reg == 2'd1) base_q[i] <= cfg_wdata[31:16];
      end
    end
    for (int r = 0; r < REMAP_WIN; r++) begin
      if (!rst_n) begin
        rlo_q[r] <= '0;
        rhi_q[r] <= '0;
      end else if (cfg_we && cfg_win == WIN_W'(r)) begin
        if (cfg_reg == 2'd2) rlo_q[r] <= cfg_wdata[31:16];
        if (cfg_reg == 2'd3) rhi_q[r] <= cfg_wdata;
      end
    end
  end

  logic [31:0] rd_val;
  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (cfg_win == WIN_W'(i)) begin
        if (cfg_reg == 2'd0)
          rd_val = {size_q[i], attr_q[i], 2'b00, en_q[i], 1'b0, tgt_q[i]};
        if (cfg_reg == 2'd1)
          rd_val = {base_q[i], 16'h0000};
      end
    end
    for (int r = 0; r < REMAP_WIN; r++) begin
      if (cfg_win == WIN_W'(r)) begin
        if (cfg_reg == 2'd2) rd_val = {rlo_q[r], 16'h0000};
        if (cfg_reg == 2'd3) rd_val = rhi_q[r];
      end
    end
  end

  logic [NUM_WIN-1:0] match;
  always_comb
    for (int i = 0; i < NUM_WIN; i++)
      match[i] = en_q[i] && ((lk_addr[31:16] & ~size_q[i]) == (base_q[i] & ~size_q[i]));

  logic [WIN_W-1:0] sel;
  always_comb begin
    sel = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--)
      if (match[i]) sel = WIN_W'(i);
  end

  wire any_hit = |match;

  logic [31:0] nx_addr, nx_hi;
  always_comb begin
    nx_addr = lk_addr;
    nx_hi   = '0;
    for (int r = 0; r < REMAP_WIN; r++) begin
      if (any_hit && sel == WIN_W'(r)) begin
        nx_addr = {(rlo_q[r] & ~size_q[r]) | (lk_addr[31:16] & size_q[r]), lk_addr[15:0]};
        nx_hi   = rhi_q[r];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_rdata   <= '0;
      lk_hit      <= 1'b0;
      lk_target   <= '0;
      lk_attr     <= '0;
      lk_xaddr    <= '0;
      lk_xaddr_hi <= '0;
    end else begin
      cfg_rdata   <= cfg_re ? rd_val : '0;
      lk_hit      <= any_hit;
      lk_target   <= any_hit ? tgt_q[sel] : '0;
      lk_attr     <= any_hit ? attr_q[sel] : '0;
      lk_xaddr    <= nx_addr;
      lk_xaddr_hi <= nx_hi;
    end
  end

endmodule

// File: rtl/addr_window_decoder_chk.sv
module addr_window_decoder_chk #(
  parameter int CFG_AW    = 7,
  parameter int REMAP_WIN = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_re,
  input logic [CFG_AW-1:0] cfg_addr,
  input logic [31:0]       cfg_rdata,
  input logic [31:0]       lk_addr,
  input logic              lk_hit,
  input logic [3:0]        lk_target,
  input logic [7:0]        lk_attr,
  input logic [31:0]       lk_xaddr,
  input logic [31:0]       lk_xaddr_hi
);

  logic past_ok;
  always_ff @(posedge clk) past_ok <= rst_n;

  // R10
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_target == 4'd0 && lk_attr == 8'd0 && lk_xaddr_hi == 32'd0));

  // R10
  miss_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    !lk_hit |-> lk_xaddr == $past(lk_addr));

  // R8
  upper_word_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_xaddr_hi != 32'd0 |-> lk_hit);

  // R4
  no_remap_read_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    $past(cfg_re && cfg_addr[3] && (int'(cfg_addr[CFG_AW-1:4]) >= REMAP_WIN)) |-> cfg_rdata == 32'd0);

  // R12
  idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    !$past(cfg_re) |-> cfg_rdata == 32'd0);

endmodule

bind addr_window_decoder addr_window_decoder_chk #(.CFG_AW(CFG_AW), .REMAP_WIN(REMAP_WIN)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_re(cfg_re), .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata),
  .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_target(lk_target), .lk_attr(lk_attr),
  .lk_xaddr(lk_xaddr), .lk_xaddr_hi(lk_xaddr_hi)
);

// File: tb/addr_window_decoder_tb_top.sv
module addr_window_decoder_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_re = 1'b0;
  logic [6:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata, lk_addr = '0, lk_xaddr, lk_xaddr_hi;
  logic lk_hit;
  logic [3:0] lk_target;
  logic [7:0] lk_attr;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_window_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_re(cfg_re), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lk_addr(lk_addr), .lk_hit(lk_hit),
    .lk_target(lk_target), .lk_attr(lk_attr), .lk_xaddr(lk_xaddr), .lk_xaddr_hi(lk_xaddr_hi));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int win, int rg, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 7'(win * 16 + rg * 4); cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic rd(int win, int rg, logic [31:0] exp, string tag);
    @(negedge clk);
    cfg_re = 1'b1; cfg_addr = 7'(win * 16 + rg * 4);
    @(posedge clk); #1;
    cfg_re = 1'b0;
    chk(tag, cfg_rdata, exp);
  endtask

  task automatic lk(logic [31:0] a, logic h, logic [3:0] t, logic [7:0] at,
                    logic [31:0] x, logic [31:0] hi, string tag);
    @(negedge clk);
    lk_addr = a;
    @(posedge clk); #1;
    chk({tag, " hit"}, 32'(lk_hit), 32'(h));
    chk({tag, " target"}, 32'(lk_target), 32'(t));
    chk({tag, " attr"}, 32'(lk_attr), 32'(at));
    chk({tag, " xaddr"}, lk_xaddr, x);
    chk({tag, " xaddr_hi"}, lk_xaddr_hi, hi);
  endtask

  task automatic t_reset;
    for (int w = 0; w < 8; w++) begin
      rd(w, 0, 32'h0, "R1 ctrl after reset");
      rd(w, 1, 32'h0, "R1 base after reset");
    end
    rd(0, 2, 32'h0, "R1 remap lo after reset");
    rd(1, 3, 32'h0, "R1 remap hi after reset");
    lk(32'h0000_1000, 0, 0, 0, 32'h0000_1000, 0, "R1 lookup after reset");
    lk(32'hE000_1234, 0, 0, 0, 32'hE000_1234, 0, "R1 lookup after reset");
  endtask

  task automatic t_regs;
    wr(6, 0, 32'hFFFF_FFFF);
    rd(6, 0, 32'hFFFF_FF2F, "R2 ctrl field masking");
    wr(6, 1, 32'h1234_ABCD);
    rd(6, 1, 32'h1234_0000, "R3 base low bits");
    wr(3, 2, 32'hDEAD_BEEF);
    wr(3, 3, 32'hCAFE_F00D);
    rd(3, 2, 32'h0, "R4 remap lo absent on window 3");
    rd(3, 3, 32'h0, "R4 remap hi absent on window 3");
    rd(3, 0, 32'h0, "R4 window 3 ctrl untouched");
    wr(1, 2, 32'hABCD_1234);
    wr(1, 3, 32'h0000_0005);
    rd(1, 2, 32'hABCD_0000, "R3 remap lo low bits");
    rd(1, 3, 32'h0000_0005, "R4 remap hi full word");
    wr(6, 0, 32'h0); wr(6, 1, 32'h0);
    rd(6, 0, 32'h0, "R2 ctrl cleared");
  endtask

  task automatic t_basic_hit;
    wr(2, 1, 32'hE000_0000);
    wr(2, 0, 32'h07FF_5923);
    lk(32'hE000_0000, 1, 3, 8'h59, 32'hE000_0000, 0, "R5 hit at base");
    lk(32'hE7FF_FFFC, 1, 3, 8'h59, 32'hE7FF_FFFC, 0, "R9 hit at top, no remap");
    lk(32'hE800_0000, 0, 0, 0, 32'hE800_0000, 0, "R5 one past top misses");
    lk(32'hDFFF_FFFF, 0, 0, 0, 32'hDFFF_FFFF, 0, "R10 below base misses");
  endtask

  task automatic t_enable;
    wr(3, 1, 32'hE800_0000);
    wr(3, 0, 32'h07FF_5904);
    lk(32'hE800_0010, 0, 0, 0, 32'hE800_0010, 0, "R6 disabled window");
    wr(3, 0, 32'h07FF_5924);
    lk(32'hE800_0010, 1, 4, 8'h59, 32'hE800_0010, 0, "R11 enable seen next cycle");
  endtask

  task automatic t_priority;
    wr(5, 1, 32'hE000_0000);
    wr(5, 0, 32'h0000_0F21);
    lk(32'hE000_0100, 1, 3, 8'h59, 32'hE000_0100, 0, "R7 window 2 beats window 5");
    wr(0, 1, 32'hE000_0000);
    wr(0, 2, 32'h4000_0000);
    wr(0, 3, 32'h0000_0007);
    wr(0, 0, 32'h0000_1E20);
    lk(32'hE000_ABCD, 1, 0, 8'h1E, 32'h4000_ABCD, 32'h7, "R7 R8 window 0 remaps");
    lk(32'hE001_0000, 1, 3, 8'h59, 32'hE001_0000, 0, "R7 next granule falls to window 2");
  endtask

  task automatic t_remap_size;
    wr(1, 1, 32'hF000_0000);
    wr(1, 2, 32'h1230_0000);
    wr(1, 0, 32'h000F_5121);
    lk(32'hF00A_5678, 1, 1, 8'h51, 32'h123A_5678, 32'h5, "R8 merge of remap and offset");
    lk(32'hF010_0000, 0, 0, 0, 32'hF010_0000, 0, "R10 miss after remap window");
  endtask

  task automatic t_clear;
    for (int w = 0; w < 8; w++) begin
      wr(w, 0, 32'h0);
      wr(w, 1, 32'h0);
    end
    lk(32'hE000_0100, 0, 0, 0, 32'hE000_0100, 0, "R1 all cleared miss");
    lk(32'h0000_0000, 0, 0, 0, 32'h0000_0000, 0, "R6 zeroed window at base 0");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_regs();
    t_basic_hit();
    t_enable();
    t_priority();
    t_remap_size();
    t_clear();
    @(negedge clk);
    chk("R12 idle read data", cfg_rdata, 32'h0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule